// File: doc/BRIEF.md
# Four-Mode Test Register

This block is a parameterised register of `WIDTH` flops that can play four roles under a two-bit mode code. It can hold system data, shift as a serial scan chain, run on its own as a pseudo-random pattern source, or fold parallel responses into a running signature. The same flops therefore act as the stimulus source for one circuit under test and as the response compactor for another. Changing the mode code between runs swaps these roles.

The feedback polynomial has every power from 0 to `WIDTH`, so every stage is a tap by default. A `TAPS` parameter allows another mask. In pattern and signature modes the register shifts toward the high end. Stage 0 takes the XOR of the tapped stages, and in signature mode each stage also XORs in its own parallel input bit. The register can be cleared in either of two ways: shift in `WIDTH` zeros in scan mode, or use the synchronous reset.

Top module: `mode_test_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, `q` becomes all zeros after that edge, whatever the mode.
- R2: Mode code 2'b00 (scan): `q[0]` takes `scan_in` and `q[i]` takes the old `q[i-1]`; `z` has no effect.
- R3: Mode code 2'b01 (pattern): `q[i]` takes the old `q[i-1]` and `q[0]` takes the XOR of all old stages selected by `TAPS` (all ones by default); `z` has no effect, and an all-zero register stays all zero.
- R4: Mode code 2'b10 (system): `q` takes `z` in one clock.
- R5: Mode code 2'b11 (signature): `q[0]` takes the tap XOR XORed with `z[0]`, and `q[i]` takes the old `q[i-1]` XORed with `z[i]`. The signature after a fixed input sequence equals the value computed from this rule.
- R6: `scan_out` equals `q[WIDTH-1]` in every mode.
- R7: Shifting `WIDTH` zeros through scan mode leaves `q` all zero from any starting value.
- R8: A change of mode code takes effect at the next clock edge and starts from the register's current contents, with no lost or extra cycle.
- R9: With the default all-ones taps, `WIDTH+1` clocks in pattern mode return the register to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 2 | 00 scan, 01 pattern, 10 system, 11 signature |
| z | input | WIDTH | Parallel data / response input |
| scan_in | input | 1 | Serial input to stage 0 |
| q | output | WIDTH | Register contents |
| scan_out | output | 1 | Last stage, `q[WIDTH-1]` |

## Verification
The system mode is loaded with patterns that have mixed bit values, all ones and all zeros, so that a swapped or stuck bit shows. Scan and pattern modes run with a busy `z` input, so any leak of parallel data into these modes is caught. Pattern mode is started both from zero, to test the lock-up state, and from a seeded value held for a full `WIDTH+1` cycle period. The signature mode folds in a varying sequence and ends at a single signature. Any error in the taps or the per-stage XOR changes that final value.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
   typedef enum logic [1:0] {
      TSR_SHIFT = 2'b00,
      TSR_PRPG  = 2'b01,
      TSR_SYS   = 2'b10,
      TSR_SIG   = 2'b11
   } tsr_mode_e;
endpackage

// File: rtl/tsr_feedback.sv
// Tap network: XOR of all stages enabled in TAPS.
module tsr_feedback #(
   parameter int unsigned          WIDTH = 8,
   parameter logic [WIDTH-1:0]     TAPS  = '1
) (
   input  logic [WIDTH-1:0] state,
   output logic             fb
);
   localparam bit FULL = (TAPS == {WIDTH{1'b1}});

   generate
      if (FULL) begin : g_full
         assign fb = ^state;
      end else begin : g_masked
         assign fb = ^(state & TAPS);
      end
   endgenerate
endmodule

// File: rtl/tsr_cell.sv
// One stage of the register with its four-way next-state select.
module tsr_cell
   import tsr_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  tsr_mode_e mode,
   input  logic      shift_in,
   input  logic      link_in,
   input  logic      z_bit,
   output logic      q
);
   logic d;

   always_comb begin
      unique case (mode)
         TSR_SHIFT: d = shift_in;
         TSR_PRPG:  d = link_in;
         TSR_SYS:   d = z_bit;
         TSR_SIG:   d = link_in ^ z_bit;
         default:   d = q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= d;
   end
endmodule

// File: rtl/mode_test_reg.sv
module mode_test_reg
   import tsr_pkg::*;
#(
   parameter int unsigned          WIDTH = 8,
   parameter logic [WIDTH-1:0]     TAPS  = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       mode,
   input  logic [WIDTH-1:0] z,
   input  logic             scan_in,
   output logic [WIDTH-1:0] q,
   output logic             scan_out
);
   localparam int unsigned LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_chk_width
      $error("mode_test_reg: WIDTH must be at least 2");
   end
   if (TAPS[LAST] != 1'b1) begin : g_chk_taps
      $error("mode_test_reg: top stage must be a tap");
   end

   tsr_mode_e mode_e;
   logic      fb;

   assign mode_e = tsr_mode_e'(mode);

   tsr_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) fb_i (
      .state (q),
      .fb    (fb)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         tsr_cell cell_i (
            .clk      (clk),
            .rst      (rst),
            .mode     (mode_e),
            .shift_in (scan_in),
            .link_in  (fb),
            .z_bit    (z[0]),
            .q        (q[0])
         );
      end else begin : g_body
         tsr_cell cell_i (
            .clk      (clk),
            .rst      (rst),
            .mode     (mode_e),
            .shift_in (q[i-1]),
            .link_in  (q[i-1]),
            .z_bit    (z[i]),
            .q        (q[i])
         );
      end
   end

   assign scan_out = q[LAST];
endmodule

// File: rtl/mode_test_reg_chk.sv
module mode_test_reg_chk #(
   parameter int unsigned          WIDTH = 8,
   parameter logic [WIDTH-1:0]     TAPS  = '1
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       mode,
   input logic [WIDTH-1:0] z,
   input logic             scan_in,
   input logic [WIDTH-1:0] q,
   input logic             scan_out
);
   logic seen;
   always_ff @(posedge clk) seen <= 1'b1;

   assert_clear_R1: assert property (@(posedge clk)
      rst |=> (q == '0));

   assert_scan_shift_R2: assert property (@(posedge clk) disable iff (rst)
      (seen && mode == 2'b00) |=> (q == {$past(q[WIDTH-2:0]), $past(scan_in)}));

   assert_pattern_step_R3: assert property (@(posedge clk) disable iff (rst)
      (seen && mode == 2'b01) |=> (q == {$past(q[WIDTH-2:0]), ^($past(q) & TAPS)}));

   assert_sys_load_R4: assert property (@(posedge clk) disable iff (rst)
      (seen && mode == 2'b10) |=> (q == $past(z)));

   assert_sig_fold_R5: assert property (@(posedge clk) disable iff (rst)
      (seen && mode == 2'b11) |=>
      (q == ({$past(q[WIDTH-2:0]), ^($past(q) & TAPS)} ^ $past(z))));

   assert_tail_out_R6: assert property (@(posedge clk) disable iff (rst)
      seen |-> (scan_out == q[WIDTH-1]));
endmodule

bind mode_test_reg mode_test_reg_chk #(.WIDTH(WIDTH), .TAPS(TAPS)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .mode     (mode),
   .z        (z),
   .scan_in  (scan_in),
   .q        (q),
   .scan_out (scan_out)
);

// File: tb/mode_test_reg_tb_top.sv
`timescale 1ns/1ps
module mode_test_reg_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic [1:0]   mode;
   logic [W-1:0] z;
   logic         scan_in;
   logic [W-1:0] q;
   logic         scan_out;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] model;
   logic [1:0]   last_md;

   always #4 clk = ~clk;

   mode_test_reg #(.WIDTH(W)) dut_i (
      .clk(clk), .rst(rst), .mode(mode), .z(z),
      .scan_in(scan_in), .q(q), .scan_out(scan_out)
   );

   // Behavioural reference: shift toward the top, all-ones polynomial.
   function automatic logic [W-1:0] ref_next(input logic [1:0] md,
         input logic [W-1:0] s, input logic [W-1:0] zv, input logic si);
      logic par = 1'b0;
      for (int i = 0; i < W; i++) par = par ^ s[i];
      case (md)
         2'b00:   return (s << 1) | W'(si);
         2'b01:   return (s << 1) | W'(par);
         2'b10:   return zv;
         default: return ((s << 1) | W'(par)) ^ zv;
      endcase
   endfunction

   function automatic string tag_of(input logic [1:0] md);
      case (md)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input string req, input logic [W-1:0] got,
                        input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic step(input logic [1:0] md, input logic [W-1:0] zv,
                       input logic si);
      mode = md; z = zv; scan_in = si; rst = 1'b0;
      @(posedge clk);
      model = ref_next(md, model, zv, si);
      @(negedge clk);
      check(tag_of(md), q, model);
      check("R6", W'(scan_out), W'(model[W-1]));
      if (md != last_md) check("R8", q, model);
      last_md = md;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      model = '0;
      @(negedge clk);
      check("R1", q, '0);
      rst = 1'b0;
   endtask

   initial begin
      #(8 * 20000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; mode = 2'b10; z = '0; scan_in = 1'b0;
      model = '0; last_md = 2'b10;
      @(negedge clk);
      do_reset();

      // R4: system loads
      step(2'b10, 8'hA5, 1'b0);
      step(2'b10, 8'h3C, 1'b1);
      step(2'b10, 8'hFF, 1'b0);
      step(2'b10, 8'h00, 1'b1);
      step(2'b10, 8'h96, 1'b0);

      // R2: scan with busy z
      for (int k = 0; k < 10; k++)
         step(2'b00, W'(k * 53 + 17), 1'((k * 5 + 1) % 3 == 0));

      // R7: clear by shifting zeros
      step(2'b10, 8'hFF, 1'b0);
      for (int k = 0; k < W; k++) step(2'b00, 8'hFF, 1'b0);
      check("R7", q, '0);

      // R3: zero state locks in pattern mode, z ignored
      for (int k = 0; k < 5; k++) step(2'b01, W'(k * 91 + 7), 1'b1);
      check("R3", q, '0);

      // R9: period WIDTH+1 from a seed
      step(2'b10, 8'hA5, 1'b0);
      for (int k = 0; k < W + 1; k++) step(2'b01, W'(k * 29 + 3), 1'b0);
      check("R9", q, 8'hA5);

      // R8: mode hops on live contents
      step(2'b10, 8'h5B, 1'b0);
      step(2'b01, 8'h11, 1'b1);
      step(2'b11, 8'h22, 1'b0);
      step(2'b00, 8'h33, 1'b1);
      step(2'b01, 8'h44, 1'b0);
      step(2'b10, 8'h55, 1'b1);
      step(2'b11, 8'h66, 1'b1);

      // R5: signature from cleared start
      do_reset();
      for (int k = 0; k < 16; k++) step(2'b11, W'(k * 37 + 5), 1'b0);
      check("R5", q, model);

      // R1: reset mid-run
      step(2'b11, 8'hC3, 1'b1);
      do_reset();
      step(2'b01, 8'hFF, 1'b1);
      check("R1", q, '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule